// File: doc/BRIEF.md
# Switching-Noise Stress Pattern Generator

This block drives a wide parallel single-ended bus with a stimulus for measuring simultaneous switching noise. A runtime index picks one victim lane, which carries a long pseudo-random sequence. The lane just below the victim and the lane just above it are crosstalk aggressors. Each of them runs its own shorter pseudo-random sequence.

Every other lane is a supply-noise aggressor. All of these lanes carry one shared bit stream. That stream is gated into bursts: an on phase of either alternating bits or pseudo-random bits, then an off phase of zeros. Software chooses the on and off lengths so that the burst envelope repeats at the resonant frequency of the supply network. Inside a burst, the bits still change at the full data rate.

The configuration inputs are victim index, mode, on length and off length. They take effect only at the start of a burst period, so each period keeps a consistent configuration. The data output is registered. It advances one bit per cycle whenever enable is high.

Top module: `ssn_pattern_gen`

## Requirements
- R1: While reset is high, and in the first cycle after it, dataOut is all zeros. After reset every sequence source restarts from its seed, and the first enabled cycle is position 0 of an on phase.
- R2: The victim lane carries the most significant bit of a 15-bit Fibonacci shift register with feedback bit14 XOR bit13 (x^15+x^14+1). The register shifts left, the feedback enters at bit 0, it is seeded with 15'h1ACE, and it steps once per enabled cycle.
- R3: The lane at victim-1 carries the MSB of a 10-bit register with feedback bit9 XOR bit6 (x^10+x^7+1), seeded with 10'h2B5. The lane at victim+1 carries the MSB of a second register of the same form, seeded with 10'h13C. Both registers step on every enabled cycle.
- R4: Every lane other than the victim and its neighbours carries the same bit in every cycle.
- R5: When modeSel=0 (toggling), the shared aggressor bit is 1 at even positions of the on phase and 0 at odd positions, with position 0 giving 1. It is 0 throughout the off phase.
- R6: When modeSel=1 (random), the shared aggressor bit during the on phase is the MSB of a 9-bit register with feedback bit8 XOR bit4, seeded with 9'h0F1, which steps on every enabled cycle. It is 0 during the off phase.
- R7: A burst period is an on phase of onLen enabled cycles followed by an off phase of offLen enabled cycles, after which the next period begins. An onLen of 0 counts as 1.
- R8: An offLen of 0 gives continuous on phases. The toggling pattern restarts at 1 at each period boundary.
- R9: victimSel, modeSel, onLen and offLen are sampled only in the first enabled cycle of a period. Changes at any other time have no effect until the next period.
- R10: A victim on lane 0 or lane LANES-1 has only one neighbour. That neighbour is driven as in R3, and every other lane is a shared aggressor. A victimSel above LANES-1 selects lane LANES-1.
- R11: While en is low, dataOut, the burst position and every sequence source hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Advance one bit time when high |
| victimSel | input | IDX_W | Victim lane index |
| modeSel | input | 1 | Aggressor mode: 0 toggling, 1 random |
| onLen | input | LEN_W | On-phase length in cycles |
| offLen | input | LEN_W | Off-phase length in cycles |
| dataOut | output | LANES | Registered stress pattern |

## Verification
Every output bit is registered once, so the inputs present before clock edge k appear on dataOut just after edge k. The bench drives its inputs at the falling edge, samples one time unit after the rising edge, and compares against a reference model that it advances in the same step.

Configuration reaches the output only in a cycle whose model position is 0. Mid-period changes therefore show up in the first cycle of the next period and no earlier, and the reference applies them at exactly that point. Idle cycles step neither the model nor the design, so the next expected value is the held one.

// File: rtl/ssn_pkg.sv
package ssn_pkg;

  // Width used to carry a lane index inside the control strobe bundle.
  localparam int VIC_W = 8;

  typedef enum logic {
    MODE_TOGGLE = 1'b0,
    MODE_RANDOM = 1'b1
  } burst_mode_e;

  // Strobes from the burst control to the lane datapath.
  typedef struct packed {
    logic              step;       // advance one bit time
    logic              onPhase;    // current cycle is inside the on phase
    logic              toggleBit;  // alternating bit for toggling mode
    burst_mode_e       mode;       // effective aggressor mode
    logic [VIC_W-1:0]  victim;     // effective, clamped victim lane
  } lane_ctrl_t;

endpackage

// File: rtl/ssn_lfsr.sv
module ssn_lfsr #(
  parameter int         W    = 15,
  parameter int         TAP  = 13,
  parameter logic [W-1:0] SEED = '1
) (
  input  logic clk,
  input  logic rst,
  input  logic adv,
  output logic bitOut
);

  logic [W-1:0] state;
  logic         feedback;

  assign feedback = state[W-1] ^ state[TAP];
  assign bitOut   = state[W-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= SEED;
    end else if (adv) begin
      state <= {state[W-2:0], feedback};
    end
  end

endmodule

// File: rtl/ssn_burst_ctrl.sv
module ssn_burst_ctrl
  import ssn_pkg::*;
#(
  parameter int LANES = 48,
  parameter int IDX_W = 6,
  parameter int LEN_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic [IDX_W-1:0] victimSel,
  input  logic             modeSel,
  input  logic [LEN_W-1:0] onLen,
  input  logic [LEN_W-1:0] offLen,
  output lane_ctrl_t       strb,
  output logic             atPeriodStart
);

  localparam int POS_W = LEN_W + 1;
  localparam logic [VIC_W-1:0] LAST_LANE = VIC_W'(LANES - 1);

  logic [POS_W-1:0] pos;
  logic [VIC_W-1:0] cfgVic;
  burst_mode_e      cfgMode;
  logic [LEN_W-1:0] cfgOn;
  logic [LEN_W-1:0] cfgOff;

  logic [VIC_W-1:0] vicClamped;
  logic [VIC_W-1:0] effVic;
  burst_mode_e      effMode;
  logic [LEN_W-1:0] effOn;
  logic [LEN_W-1:0] effOff;
  logic [POS_W-1:0] onSpan;
  logic [POS_W-1:0] periodLen;
  logic [POS_W-1:0] posNext;

  assign atPeriodStart = (pos == '0);

  always_comb begin
    vicClamped = VIC_W'(victimSel);
    if (vicClamped > LAST_LANE) vicClamped = LAST_LANE;
  end

  // Inputs are used directly in the first cycle of a period, latched copies afterwards.
  assign effVic  = atPeriodStart ? vicClamped : cfgVic;
  assign effMode = atPeriodStart ? burst_mode_e'(modeSel) : cfgMode;
  assign effOn   = atPeriodStart ? onLen : cfgOn;
  assign effOff  = atPeriodStart ? offLen : cfgOff;

  assign onSpan    = (effOn == '0) ? POS_W'(1) : {1'b0, effOn};
  assign periodLen = onSpan + {1'b0, effOff};
  assign posNext   = pos + POS_W'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      pos     <= '0;
      cfgVic  <= '0;
      cfgMode <= MODE_TOGGLE;
      cfgOn   <= '0;
      cfgOff  <= '0;
    end else if (en) begin
      if (atPeriodStart) begin
        cfgVic  <= vicClamped;
        cfgMode <= burst_mode_e'(modeSel);
        cfgOn   <= onLen;
        cfgOff  <= offLen;
      end
      pos <= (posNext == periodLen) ? '0 : posNext;
    end
  end

  always_comb begin
    strb.step      = en;
    strb.onPhase   = (pos < onSpan);
    strb.toggleBit = ~pos[0];
    strb.mode      = effMode;
    strb.victim    = effVic;
  end

endmodule

// File: rtl/ssn_lane_dp.sv
module ssn_lane_dp
  import ssn_pkg::*;
#(
  parameter int           LANES      = 48,
  parameter logic [14:0]  VIC_SEED   = 15'h1ACE,
  parameter logic [9:0]   XT_LO_SEED = 10'h2B5,
  parameter logic [9:0]   XT_HI_SEED = 10'h13C,
  parameter logic [8:0]   AGG_SEED   = 9'h0F1
) (
  input  logic             clk,
  input  logic             rst,
  input  lane_ctrl_t       strb,
  output logic [LANES-1:0] dataOut
);

  logic       victimBit;
  logic [1:0] xtBits;     // [0] lane below victim, [1] lane above
  logic       aggRaw;
  logic       aggBit;
  logic [LANES-1:0] laneBits;

  ssn_lfsr #(.W(15), .TAP(13), .SEED(VIC_SEED)) u_vicGen (
    .clk(clk), .rst(rst), .adv(strb.step), .bitOut(victimBit)
  );

  for (genvar k = 0; k < 2; k++) begin : g_xt
    localparam logic [9:0] XT_SEED = (k == 0) ? XT_LO_SEED : XT_HI_SEED;
    ssn_lfsr #(.W(10), .TAP(6), .SEED(XT_SEED)) u_xtGen (
      .clk(clk), .rst(rst), .adv(strb.step), .bitOut(xtBits[k])
    );
  end

  ssn_lfsr #(.W(9), .TAP(4), .SEED(AGG_SEED)) u_aggGen (
    .clk(clk), .rst(rst), .adv(strb.step), .bitOut(aggRaw)
  );

  always_comb begin
    if (!strb.onPhase)               aggBit = 1'b0;
    else if (strb.mode == MODE_RANDOM) aggBit = aggRaw;
    else                             aggBit = strb.toggleBit;
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    localparam logic [VIC_W-1:0] SELF = VIC_W'(g);
    localparam logic [VIC_W-1:0] UP   = VIC_W'(g + 1);
    logic isAbove;
    if (g == 0) begin : g_first
      assign isAbove = 1'b0;
    end else begin : g_rest
      localparam logic [VIC_W-1:0] DOWN = VIC_W'(g - 1);
      assign isAbove = (strb.victim == DOWN);
    end
    always_comb begin
      if (strb.victim == SELF)    laneBits[g] = victimBit;
      else if (strb.victim == UP) laneBits[g] = xtBits[0];
      else if (isAbove)           laneBits[g] = xtBits[1];
      else                        laneBits[g] = aggBit;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)            dataOut <= '0;
    else if (strb.step) dataOut <= laneBits;
  end

endmodule

// File: rtl/ssn_pattern_gen.sv
module ssn_pattern_gen
  import ssn_pkg::*;
#(
  parameter int          LANES      = 48,
  parameter int          LEN_W      = 8,
  parameter int          IDX_W      = $clog2(LANES),
  parameter logic [14:0] VIC_SEED   = 15'h1ACE,
  parameter logic [9:0]  XT_LO_SEED = 10'h2B5,
  parameter logic [9:0]  XT_HI_SEED = 10'h13C,
  parameter logic [8:0]  AGG_SEED   = 9'h0F1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic [IDX_W-1:0] victimSel,
  input  logic             modeSel,
  input  logic [LEN_W-1:0] onLen,
  input  logic [LEN_W-1:0] offLen,
  output logic [LANES-1:0] dataOut
);

  lane_ctrl_t strb;
  logic       atPeriodStart;

  ssn_burst_ctrl #(.LANES(LANES), .IDX_W(IDX_W), .LEN_W(LEN_W)) u_ctrl (
    .clk(clk), .rst(rst), .en(en), .victimSel(victimSel), .modeSel(modeSel),
    .onLen(onLen), .offLen(offLen), .strb(strb), .atPeriodStart(atPeriodStart)
  );

  ssn_lane_dp #(
    .LANES(LANES), .VIC_SEED(VIC_SEED), .XT_LO_SEED(XT_LO_SEED),
    .XT_HI_SEED(XT_HI_SEED), .AGG_SEED(AGG_SEED)
  ) u_dp (
    .clk(clk), .rst(rst), .strb(strb), .dataOut(dataOut)
  );

endmodule

// File: rtl/ssn_pattern_gen_chk.sv
module ssn_pattern_gen_chk
  import ssn_pkg::*;
#(
  parameter int LANES = 48
) (
  input logic             clk,
  input logic             rst,
  input logic             en,
  input logic [LANES-1:0] dataOut,
  input lane_ctrl_t       strb,
  input logic             atPeriodStart
);

  // R1
  reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (dataOut == '0));

  // R11
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !en |=> $stable(dataOut));

  // R5
  quiet_off_phase_chk: assert property (@(posedge clk) disable iff (rst)
    (en && !strb.onPhase) |=> ($countones(dataOut) <= 3));

  // R9
  cfg_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !atPeriodStart |-> ($stable(strb.victim) && $stable(strb.mode)));

  // R10
  victim_range_chk: assert property (@(posedge clk) disable iff (rst)
    strb.victim < VIC_W'(LANES));

endmodule

bind ssn_pattern_gen ssn_pattern_gen_chk #(.LANES(LANES)) u_chk (
  .clk(clk), .rst(rst), .en(en), .dataOut(dataOut),
  .strb(strb), .atPeriodStart(atPeriodStart)
);

// File: tb/ssn_pattern_gen_bench.sv
module ssn_pattern_gen_bench;

  localparam int CLK_PERIOD = 10;
  localparam int LANES = 48;
  localparam int LEN_W = 8;
  localparam int IDX_W = 6;

  logic clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  logic             rst;
  logic             en;
  logic [IDX_W-1:0] victimSel;
  logic             modeSel;
  logic [LEN_W-1:0] onLen;
  logic [LEN_W-1:0] offLen;
  logic [LANES-1:0] dataOut;

  ssn_pattern_gen u_ssn_pattern_gen (
    .clk(clk), .rst(rst), .en(en), .victimSel(victimSel), .modeSel(modeSel),
    .onLen(onLen), .offLen(offLen), .dataOut(dataOut)
  );

  int total = 0;
  int bad = 0;

  // Reference model state
  logic [14:0] mV;
  logic [9:0]  mLo, mHi;
  logic [8:0]  mA;
  int          mPos, cVic, cOn, cOff;
  logic        cMode;
  logic [LANES-1:0] expOut;

  task automatic model_reset();
    mV = 15'h1ACE; mLo = 10'h2B5; mHi = 10'h13C; mA = 9'h0F1;
    mPos = 0; cVic = 0; cOn = 0; cOff = 0; cMode = 1'b0;
    expOut = '0;
  endtask

  task automatic check(input string tag);
    total++;
    if (dataOut !== expOut) begin
      bad++;
      $display("FAIL %s: dataOut got %h expected %h", tag, dataOut, expOut);
    end
  endtask

  task automatic drive(input logic e, input int v, input logic m,
                       input int on, input int off, input string tag);
    int onS;
    logic agg;
    @(negedge clk);
    en = e; victimSel = IDX_W'(v); modeSel = m;
    onLen = LEN_W'(on); offLen = LEN_W'(off);
    if (e) begin
      if (mPos == 0) begin
        cVic = (v > LANES - 1) ? LANES - 1 : v;
        cMode = m; cOn = on; cOff = off;
      end
      onS = (cOn == 0) ? 1 : cOn;
      if (mPos >= onS) agg = 1'b0;
      else if (cMode)  agg = mA[8];
      else             agg = ((mPos % 2) == 0);
      for (int l = 0; l < LANES; l++) begin
        if (l == cVic)          expOut[l] = mV[14];
        else if (l == cVic - 1) expOut[l] = mLo[9];
        else if (l == cVic + 1) expOut[l] = mHi[9];
        else                    expOut[l] = agg;
      end
      mV  = {mV[13:0],  mV[14] ^ mV[13]};
      mLo = {mLo[8:0],  mLo[9] ^ mLo[6]};
      mHi = {mHi[8:0],  mHi[9] ^ mHi[6]};
      mA  = {mA[7:0],   mA[8] ^ mA[4]};
      mPos = (mPos + 1 == onS + cOff) ? 0 : mPos + 1;
    end
    @(posedge clk);
    #1;
    check(tag);
  endtask

  task automatic align(input int v, input logic m, input int on, input int off,
                       input string tag);
    while (mPos != 0) drive(1'b1, v, m, on, off, tag);
  endtask

  task automatic t_reset();
    rst = 1'b1; en = 1'b0; victimSel = '0; modeSel = 1'b0; onLen = '0; offLen = '0;
    repeat (3) @(posedge clk);
    #1;
    model_reset();
    check("R1 during reset");
    @(negedge clk);
    rst = 1'b0;
    @(posedge clk);
    #1;
    check("R1 first cycle after reset");
  endtask

  task automatic t_toggle();
    for (int i = 0; i < 21; i++) drive(1'b1, 10, 1'b0, 4, 3, "R2 R3 R4 R5 R7 toggling");
  endtask

  task automatic t_random();
    align(20, 1'b1, 5, 2, "R6 align");
    for (int i = 0; i < 21; i++) drive(1'b1, 20, 1'b1, 5, 2, "R6 random burst");
  endtask

  task automatic t_zero_on();
    align(7, 1'b0, 0, 2, "R7 align");
    for (int i = 0; i < 9; i++) drive(1'b1, 7, 1'b0, 0, 2, "R7 zero on length");
  endtask

  task automatic t_continuous();
    align(15, 1'b0, 3, 0, "R8 align");
    for (int i = 0; i < 12; i++) drive(1'b1, 15, 1'b0, 3, 0, "R8 continuous");
  endtask

  task automatic t_midchange();
    align(5, 1'b0, 6, 2, "R9 align");
    drive(1'b1, 5, 1'b0, 6, 2, "R9 period start");
    for (int i = 0; i < 7; i++) drive(1'b1, 30, 1'b1, 2, 1, "R9 ignored mid-period");
    for (int i = 0; i < 6; i++) drive(1'b1, 30, 1'b1, 2, 1, "R9 new period");
  endtask

  task automatic t_edges();
    align(0, 1'b0, 3, 2, "R10 align");
    for (int i = 0; i < 5; i++) drive(1'b1, 0, 1'b0, 3, 2, "R10 victim lane 0");
    for (int i = 0; i < 5; i++) drive(1'b1, LANES - 1, 1'b1, 3, 2, "R10 victim last lane");
    for (int i = 0; i < 5; i++) drive(1'b1, 60, 1'b0, 3, 2, "R10 clamped index");
  endtask

  task automatic t_idle();
    align(12, 1'b1, 4, 4, "R11 align");
    drive(1'b1, 12, 1'b1, 4, 4, "R11 before idle");
    drive(1'b1, 12, 1'b1, 4, 4, "R11 before idle");
    for (int i = 0; i < 5; i++) drive(1'b0, 3, 1'b0, 1, 0, "R11 idle hold");
    for (int i = 0; i < 8; i++) drive(1'b1, 12, 1'b1, 4, 4, "R11 resume");
  endtask

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", total, bad);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    total++;
    bad++;
    $display("FAIL watchdog: run did not complete, got timeout expected finish");
    summary();
    $finish;
  end

  initial begin
    t_reset();
    t_toggle();
    t_random();
    t_zero_on();
    t_continuous();
    t_midchange();
    t_edges();
    t_idle();
    summary();
    $finish;
  end

endmodule